// File: doc/BRIEF.md
# Exception Entry Vector Unit

This unit works out the architectural state that follows when a processor takes an exception. A single-cycle `take_i` strobe supplies the exception kind and its context: the faulting PC, whether the faulting instruction sat in a branch delay slot, whether that branch or the running code used the compressed instruction encoding, the current status flags, the exception base register, the interrupt lines, and, for address faults, the faulting virtual address and the current address-space ID. On the next clock edge the unit registers the handler PC and the return PC. It also registers the status flags, the delay-slot flag and the 5-bit cause code, and for address faults the bad-address, context and entry-high values.

Reset-class events (hard reset, soft reset and NMI) save their return PC in a separate error-return register and go to the boot vector. All other exceptions save into the normal return register, but only when no exception is already in progress. Interrupts can use a fixed offset or a vectored offset. In vectored mode the highest pending unmasked line picks a slot, and the slots are separated by a programmable spacing. When `take_i` is low, the status mirror follows the status inputs and every other register keeps its value.

Top module: `exc_entry_unit`

## Requirements
- R1: The return PC is `pc_i | isa_cmp_i`. When `in_delay_i` is set, this value is reduced by 2 if `delay_cmp_i` is set and by 4 otherwise.
- R2: A non-reset exception taken with `exl_i` clear loads the return PC into `epc_o` and the delay-slot flag into `bd_o`.
- R3: A non-reset exception taken with `exl_i` set leaves `epc_o` and `bd_o` unchanged.
- R4: The handler base is 0xBFC00200 when `bev_i` is set. Otherwise it is `ebase_i` with bits 9:0 cleared. The vector offset is added to this base.
- R5: A TLB load or store fault (kind 6 or 7) with `refill_i` set and `exl_i` clear uses offset 0x000. An interrupt (kind 3) uses 0x200 when `iv_i` is set and 0x180 when it is clear. Every other non-reset exception uses 0x180.
- R6: When `iv_i` and `vint_en_i` are both set, the interrupt offset is 0x200 + v × `vec_space_i`. Here v is the highest set bit among bits 7..1 of `irq_pend_i & irq_mask_i`, and v is 0 if none of those bits is set.
- R7: Hard reset, soft reset and NMI (kinds 0, 1, 2) load the return PC into `errpc_o`, set `erl_o` and `bev_o`, and set `next_pc_o` to 0xBFC00000. They clear `bd_o` only when `exl_i` is clear, and they leave `epc_o` unchanged. After a reset of the block, `next_pc_o` is 0xBFC00000, `erl_o` and `bev_o` are 1, and `exl_o` is 0.
- R8: `exc_code_o` receives the cause code of the exception kind: interrupt 0, modify 1, TLB load 2, TLB store 3, address load 4, address store 5, syscall 8, breakpoint 9, reserved instruction 10, overflow 12, trap 13. Kind encoding: 3 interrupt, 4 address load, 5 address store, 6 TLB load, 7 TLB store, 8 modify, 9 execute-inhibit, 10 read-inhibit, 11 syscall, 12 breakpoint, 13 reserved instruction, 14 overflow, 15 trap.
- R9: Execute-inhibit reports code 20 and read-inhibit reports code 19 when `inhibit_en_i` is set. When it is clear, both report code 2.
- R10: Address faults (kinds 4 to 10) load `vaddr_i` into `badvaddr_o`. They write `vaddr_i[31:13]` into `context_o[22:4]` and set `entryhi_o` to `{vaddr_i[31:13], 5'b0, asid_i}`. Other kinds leave these three registers unchanged.
- R11: Every exception sets `ksu_o` to 0 (kernel) and clears `isa_cmp_o`. Every non-reset exception sets `exl_o`.
- R12: While `take_i` is low, `next_pc_o`, `epc_o`, `errpc_o`, `bd_o`, `exc_code_o` and the fault registers hold their values, and `exl_o`, `erl_o`, `bev_o`, `ksu_o` and `isa_cmp_o` follow their inputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| take_i | input | 1 | Exception taken this cycle |
| kind_i | input | 4 | Exception kind |
| pc_i | input | 32 | PC of the faulting instruction |
| in_delay_i | input | 1 | Fault in a branch delay slot |
| delay_cmp_i | input | 1 | The branch was compressed |
| isa_cmp_i | input | 1 | Current compressed-ISA mode |
| ksu_i | input | 2 | Current privilege mode |
| exl_i | input | 1 | Exception level flag now |
| erl_i | input | 1 | Error level flag now |
| bev_i | input | 1 | Boot vectors selected now |
| ebase_i | input | 32 | Exception base register |
| iv_i | input | 1 | Interrupts use the special offset |
| vint_en_i | input | 1 | Vectored interrupt mode |
| irq_pend_i | input | 8 | Pending interrupt lines |
| irq_mask_i | input | 8 | Interrupt line enables |
| vec_space_i | input | 10 | Vector spacing in bytes |
| refill_i | input | 1 | The TLB fault is a refill |
| inhibit_en_i | input | 1 | Separate inhibit codes enabled |
| vaddr_i | input | 32 | Faulting virtual address |
| asid_i | input | 8 | Current address-space ID |
| next_pc_o | output | 32 | Handler PC |
| epc_o | output | 32 | Saved return PC |
| errpc_o | output | 32 | Saved error-return PC |
| exl_o | output | 1 | Next exception level flag |
| erl_o | output | 1 | Next error level flag |
| bev_o | output | 1 | Next boot-vector flag |
| ksu_o | output | 2 | Next privilege mode |
| isa_cmp_o | output | 1 | Next compressed-ISA mode |
| bd_o | output | 1 | Cause delay-slot flag |
| exc_code_o | output | 5 | Cause code |
| badvaddr_o | output | 32 | Bad virtual address |
| context_o | output | 32 | Context register |
| entryhi_o | output | 32 | Entry-high register |

## Verification
Each output is a plain register, so a bad internal decision appears at the ports on the first edge after the strobe. A wrong priority pick or a wrong spacing product moves `next_pc_o` by a multiple of the spacing. A wrong delay-slot adjustment shifts `epc_o` or `errpc_o` by 2 or 4. If the nested-exception guard is broken, a previously saved return PC gets overwritten. The stimulus is chosen so that each of these faults produces a distinct value within one cycle of the take.

// File: rtl/exc_pkg.sv
package exc_pkg;
    localparam int AW = 32;

    localparam logic [3:0] K_RESET  = 4'd0;
    localparam logic [3:0] K_SRESET = 4'd1;
    localparam logic [3:0] K_NMI    = 4'd2;
    localparam logic [3:0] K_INT    = 4'd3;
    localparam logic [3:0] K_ADEL   = 4'd4;
    localparam logic [3:0] K_ADES   = 4'd5;
    localparam logic [3:0] K_TLBL   = 4'd6;
    localparam logic [3:0] K_TLBS   = 4'd7;
    localparam logic [3:0] K_MOD    = 4'd8;
    localparam logic [3:0] K_XINH   = 4'd9;
    localparam logic [3:0] K_RINH   = 4'd10;
    localparam logic [3:0] K_SYS    = 4'd11;
    localparam logic [3:0] K_BRK    = 4'd12;
    localparam logic [3:0] K_RSVD   = 4'd13;
    localparam logic [3:0] K_OVF    = 4'd14;
    localparam logic [3:0] K_TRAP   = 4'd15;

    localparam logic [AW-1:0] BOOT_VEC = 32'hBFC0_0000;
    localparam logic [AW-1:0] BEV_BASE = 32'hBFC0_0200;

    typedef struct packed {
        logic [AW-1:0] pc;
        logic [AW-1:0] epc;
        logic [AW-1:0] errpc;
        logic          exl;
        logic          erl;
        logic          bev;
        logic [1:0]    ksu;
        logic          isa;
        logic          bd;
        logic [4:0]    code;
        logic [AW-1:0] badv;
        logic [AW-1:0] ctx;
        logic [AW-1:0] ehi;
    } exc_state_t;
endpackage

// File: rtl/exc_retpc.sv
module exc_retpc #(
    parameter int AW = 32
) (
    input  logic [AW-1:0] pc,
    input  logic          isa,
    input  logic          dly,
    input  logic          dcmp,
    output logic [AW-1:0] rpc
);
    logic [AW-1:0] base;
    always_comb begin
        base = pc | AW'(isa);
        if (dly) rpc = base - (dcmp ? AW'(2) : AW'(4));
        else     rpc = base;
    end
endmodule

// File: rtl/exc_classify.sv
module exc_classify
    import exc_pkg::*;
(
    input  logic [3:0] kind,
    input  logic       inh_en,
    output logic [4:0] code,
    output logic       rst_class,
    output logic       addr_fault,
    output logic       tlb_fault,
    output logic       is_int
);
    always_comb begin
        rst_class  = (kind == K_RESET) || (kind == K_SRESET) || (kind == K_NMI);
        addr_fault = (kind >= K_ADEL) && (kind <= K_RINH);
        tlb_fault  = (kind == K_TLBL) || (kind == K_TLBS);
        is_int     = (kind == K_INT);
        unique case (kind)
            K_INT:   code = 5'd0;
            K_MOD:   code = 5'd1;
            K_TLBL:  code = 5'd2;
            K_TLBS:  code = 5'd3;
            K_ADEL:  code = 5'd4;
            K_ADES:  code = 5'd5;
            K_SYS:   code = 5'd8;
            K_BRK:   code = 5'd9;
            K_RSVD:  code = 5'd10;
            K_OVF:   code = 5'd12;
            K_TRAP:  code = 5'd13;
            K_XINH:  code = inh_en ? 5'd20 : 5'd2;
            K_RINH:  code = inh_en ? 5'd19 : 5'd2;
            default: code = 5'd0;
        endcase
    end
endmodule

// File: rtl/exc_vector.sv
module exc_vector #(
    parameter int AW    = 32,
    parameter int LINES = 8,
    parameter int SPW   = 10
) (
    input  logic             bev,
    input  logic [AW-1:0]    ebase,
    input  logic             zero_off,
    input  logic             is_int,
    input  logic             iv,
    input  logic             vint,
    input  logic [LINES-1:0] pend,
    input  logic [LINES-1:0] mask,
    input  logic [SPW-1:0]   spacing,
    output logic [AW-1:0]    vec_pc
);
    localparam int IDX_W = $clog2(LINES);
    localparam logic [AW-1:0] OFF_GEN = AW'(32'h180);
    localparam logic [AW-1:0] OFF_INT = AW'(32'h200);

    logic [LINES-1:0] act;
    logic [IDX_W-1:0] vec;
    logic [AW-1:0]    base, off;

    always_comb begin
        act = pend & mask;
        vec = '0;
        for (int i = 1; i < LINES; i++) begin
            if (act[i]) vec = IDX_W'(i);
        end
        base = bev ? exc_pkg::BEV_BASE : {ebase[AW-1:10], 10'b0};
        if (zero_off)
            off = '0;
        else if (is_int && iv)
            off = vint ? OFF_INT + AW'(vec) * AW'(spacing) : OFF_INT;
        else
            off = OFF_GEN;
        vec_pc = base + off;
    end
endmodule

// File: rtl/exc_entry_unit.sv
module exc_entry_unit
    import exc_pkg::*;
#(
    parameter int LINES = 8,
    parameter int SPW   = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             take_i,
    input  logic [3:0]       kind_i,
    input  logic [AW-1:0]    pc_i,
    input  logic             in_delay_i,
    input  logic             delay_cmp_i,
    input  logic             isa_cmp_i,
    input  logic [1:0]       ksu_i,
    input  logic             exl_i,
    input  logic             erl_i,
    input  logic             bev_i,
    input  logic [AW-1:0]    ebase_i,
    input  logic             iv_i,
    input  logic             vint_en_i,
    input  logic [LINES-1:0] irq_pend_i,
    input  logic [LINES-1:0] irq_mask_i,
    input  logic [SPW-1:0]   vec_space_i,
    input  logic             refill_i,
    input  logic             inhibit_en_i,
    input  logic [AW-1:0]    vaddr_i,
    input  logic [7:0]       asid_i,
    output logic [AW-1:0]    next_pc_o,
    output logic [AW-1:0]    epc_o,
    output logic [AW-1:0]    errpc_o,
    output logic             exl_o,
    output logic             erl_o,
    output logic             bev_o,
    output logic [1:0]       ksu_o,
    output logic             isa_cmp_o,
    output logic             bd_o,
    output logic [4:0]       exc_code_o,
    output logic [AW-1:0]    badvaddr_o,
    output logic [AW-1:0]    context_o,
    output logic [AW-1:0]    entryhi_o
);
    localparam int VPN2_W = AW - 13;

    exc_state_t st_d, st_q;
    logic [AW-1:0] rpc, vec_pc;
    logic [4:0]    code;
    logic          rst_class, addr_fault, tlb_fault, is_int;

    exc_retpc #(.AW(AW)) u_retpc (
        .pc(pc_i), .isa(isa_cmp_i), .dly(in_delay_i), .dcmp(delay_cmp_i), .rpc(rpc)
    );

    exc_classify u_class (
        .kind(kind_i), .inh_en(inhibit_en_i), .code(code), .rst_class(rst_class),
        .addr_fault(addr_fault), .tlb_fault(tlb_fault), .is_int(is_int)
    );

    exc_vector #(.AW(AW), .LINES(LINES), .SPW(SPW)) u_vec (
        .bev(bev_i), .ebase(ebase_i), .zero_off(tlb_fault && refill_i && !exl_i),
        .is_int(is_int), .iv(iv_i), .vint(vint_en_i), .pend(irq_pend_i),
        .mask(irq_mask_i), .spacing(vec_space_i), .vec_pc(vec_pc)
    );

    always_comb begin
        st_d = st_q;
        if (!take_i) begin
            st_d.exl = exl_i;
            st_d.erl = erl_i;
            st_d.bev = bev_i;
            st_d.ksu = ksu_i;
            st_d.isa = isa_cmp_i;
        end else begin
            st_d.ksu = 2'b00;
            st_d.isa = 1'b0;
            if (rst_class) begin
                st_d.errpc = rpc;
                st_d.erl   = 1'b1;
                st_d.bev   = 1'b1;
                st_d.exl   = exl_i;
                st_d.pc    = BOOT_VEC;
                if (!exl_i) st_d.bd = 1'b0;
            end else begin
                if (!exl_i) begin
                    st_d.epc = rpc;
                    st_d.bd  = in_delay_i;
                end
                st_d.exl  = 1'b1;
                st_d.erl  = erl_i;
                st_d.bev  = bev_i;
                st_d.pc   = vec_pc;
                st_d.code = code;
            end
            if (addr_fault) begin
                st_d.badv          = vaddr_i;
                st_d.ctx[4 +: VPN2_W] = vaddr_i[AW-1:13];
                st_d.ehi           = {vaddr_i[AW-1:13], 5'b0, asid_i};
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.pc  <= BOOT_VEC;
            st_q.erl <= 1'b1;
            st_q.bev <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign next_pc_o  = st_q.pc;
    assign epc_o      = st_q.epc;
    assign errpc_o    = st_q.errpc;
    assign exl_o      = st_q.exl;
    assign erl_o      = st_q.erl;
    assign bev_o      = st_q.bev;
    assign ksu_o      = st_q.ksu;
    assign isa_cmp_o  = st_q.isa;
    assign bd_o       = st_q.bd;
    assign exc_code_o = st_q.code;
    assign badvaddr_o = st_q.badv;
    assign context_o  = st_q.ctx;
    assign entryhi_o  = st_q.ehi;

    assert_nested_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && exl_i && !rst_class |=> $stable(epc_o) && $stable(bd_o));

    assert_kernel_entry_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_i |=> ksu_o == 2'b00 && !isa_cmp_o);

    assert_level_set_R11: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && !rst_class |=> exl_o);

    assert_boot_entry_R7: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && rst_class |=> next_pc_o == BOOT_VEC && erl_o && bev_o && $stable(epc_o));

    assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
        !take_i |=> $stable(next_pc_o) && $stable(epc_o) && $stable(badvaddr_o) && $stable(exc_code_o));

    assert_asid_kept_R10: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && addr_fault |=> entryhi_o[7:0] == $past(asid_i) && badvaddr_o == $past(vaddr_i));

    assert_bev_region_R4: assert property (@(posedge clk) disable iff (!rst_n)
        take_i && bev_i && !rst_class && !is_int |=> next_pc_o[AW-1:10] == BOOT_VEC[AW-1:10]);
endmodule

// File: tb/exc_entry_unit_tb.sv
module exc_entry_unit_tb;
    import exc_pkg::*;

    localparam int CLK_PERIOD = 10;

    typedef struct packed {
        logic [3:0]  kind;
        logic [31:0] pc;
        logic        dly, dcmp, isa, exl, bev;
        logic [31:0] ebase;
        logic        iv, vint;
        logic [7:0]  pend, mask;
        logic [9:0]  spc;
        logic        refill, inh;
        logic [31:0] xpc, xepc;
        logic        xbd;
        logic [4:0]  xcode;
    } vec_t;

    localparam int NV = 22;
    localparam logic [31:0] EB = 32'h8000_0000;
    localparam vec_t TABLE [NV] = '{
        '{K_SYS,  32'h0040_0100,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0040_0100,0,5'd8},
        '{K_BRK,  32'h0040_0204,1,0,0,0,1,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'hBFC0_0380,32'h0040_0200,1,5'd9},
        '{K_OVF,  32'h0040_1000,1,1,1,0,0,32'h8001_2345,0,0,8'h00,8'h00,10'h000,0,0, 32'h8001_2180,32'h0040_0FFF,1,5'd12},
        '{K_TRAP, 32'h0050_0000,1,0,0,1,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0040_0FFF,1,5'd13},
        '{K_TLBL, 32'h0060_0000,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,1,0, 32'h8000_0000,32'h0060_0000,0,5'd2},
        '{K_TLBS, 32'h0060_0100,0,0,0,1,0,EB,0,0,8'h00,8'h00,10'h000,1,0, 32'h8000_0180,32'h0060_0000,0,5'd3},
        '{K_TLBL, 32'h0070_0008,0,0,0,0,1,EB,0,0,8'h00,8'h00,10'h000,1,0, 32'hBFC0_0200,32'h0070_0008,0,5'd2},
        '{K_INT,  32'h0070_0010,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_0010,0,5'd0},
        '{K_INT,  32'h0070_0020,0,0,0,0,0,EB,1,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0200,32'h0070_0020,0,5'd0},
        '{K_INT,  32'h0070_0030,0,0,0,0,0,EB,1,1,8'hA6,8'h3F,10'h020,0,0, 32'h8000_02A0,32'h0070_0030,0,5'd0},
        '{K_INT,  32'h0070_0040,0,0,0,0,0,EB,1,1,8'h01,8'hFF,10'h020,0,0, 32'h8000_0200,32'h0070_0040,0,5'd0},
        '{K_INT,  32'h0070_0050,0,0,0,0,0,EB,1,1,8'h80,8'h80,10'h100,0,0, 32'h8000_0900,32'h0070_0050,0,5'd0},
        '{K_XINH, 32'h0070_0060,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_0060,0,5'd2},
        '{K_XINH, 32'h0070_0070,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,1, 32'h8000_0180,32'h0070_0070,0,5'd20},
        '{K_RINH, 32'h0070_0080,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,1, 32'h8000_0180,32'h0070_0080,0,5'd19},
        '{K_RINH, 32'h0070_0090,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_0090,0,5'd2},
        '{K_MOD,  32'h0070_00A0,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_00A0,0,5'd1},
        '{K_RSVD, 32'h0070_00B0,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_00B0,0,5'd10},
        '{K_ADEL, 32'h0070_00C0,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_00C0,0,5'd4},
        '{K_ADES, 32'h0070_00D0,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_00D0,0,5'd5},
        '{K_INT,  32'h0070_00E0,0,0,0,0,1,EB,1,1,8'h04,8'h04,10'h010,0,0, 32'hBFC0_0420,32'h0070_00E0,0,5'd0},
        '{K_TLBS, 32'h0070_00F0,0,0,0,0,0,EB,0,0,8'h00,8'h00,10'h000,0,0, 32'h8000_0180,32'h0070_00F0,0,5'd3}
    };

    logic clk = 1'b0, rst_n = 1'b0, take = 1'b0;
    logic [3:0]  kind = '0;
    logic [31:0] pc = '0, ebase = EB, vaddr = '0;
    logic dly = 0, dcmp = 0, isa = 0, exl = 0, erl = 0, bev = 0, iv = 0, vint = 0, refill = 0, inh = 0;
    logic [1:0]  ksu = '0;
    logic [7:0]  pend = '0, mask = '0, asid = '0;
    logic [9:0]  spc = '0;

    logic [31:0] next_pc, epc, errpc, badv, ctx, ehi;
    logic        exl_o, erl_o, bev_o, isa_o, bd;
    logic [1:0]  ksu_o;
    logic [4:0]  code;

    int checks = 0, fails = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    exc_entry_unit u_dut (
        .clk(clk), .rst_n(rst_n), .take_i(take), .kind_i(kind), .pc_i(pc),
        .in_delay_i(dly), .delay_cmp_i(dcmp), .isa_cmp_i(isa), .ksu_i(ksu),
        .exl_i(exl), .erl_i(erl), .bev_i(bev), .ebase_i(ebase), .iv_i(iv),
        .vint_en_i(vint), .irq_pend_i(pend), .irq_mask_i(mask), .vec_space_i(spc),
        .refill_i(refill), .inhibit_en_i(inh), .vaddr_i(vaddr), .asid_i(asid),
        .next_pc_o(next_pc), .epc_o(epc), .errpc_o(errpc), .exl_o(exl_o),
        .erl_o(erl_o), .bev_o(bev_o), .ksu_o(ksu_o), .isa_cmp_o(isa_o), .bd_o(bd),
        .exc_code_o(code), .badvaddr_o(badv), .context_o(ctx), .entryhi_o(ehi)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic pulse();
        take = 1'b1;
        @(negedge clk);
        take = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [31:0] keep_epc, keep_pc;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R7: state after block reset
        chk("R7 reset pc", next_pc, 32'hBFC0_0000);
        chk("R7 reset erl/bev/exl", {29'b0, erl_o, bev_o, exl_o}, 32'd6);

        for (int i = 0; i < NV; i++) begin
            kind = TABLE[i].kind;  pc = TABLE[i].pc;   dly = TABLE[i].dly;
            dcmp = TABLE[i].dcmp;  isa = TABLE[i].isa; exl = TABLE[i].exl;
            bev = TABLE[i].bev;    ebase = TABLE[i].ebase; iv = TABLE[i].iv;
            vint = TABLE[i].vint;  pend = TABLE[i].pend;   mask = TABLE[i].mask;
            spc = TABLE[i].spc;    refill = TABLE[i].refill; inh = TABLE[i].inh;
            pulse();
            // R4 R5 R6: handler address
            chk($sformatf("R4/R5/R6 vec pc row %0d", i), next_pc, TABLE[i].xpc);
            // R1 R2 R3: return PC and delay flag
            chk($sformatf("R1/R2/R3 epc row %0d", i), epc, TABLE[i].xepc);
            chk($sformatf("R2/R3 bd row %0d", i), {31'b0, bd}, {31'b0, TABLE[i].xbd});
            // R8 R9: cause code
            chk($sformatf("R8/R9 code row %0d", i), {27'b0, code}, {27'b0, TABLE[i].xcode});
            @(negedge clk);
        end

        // R10: address fault registers
        kind = K_ADES; pc = 32'h0090_0000; dly = 0; isa = 0; exl = 0; bev = 0; ebase = EB;
        vaddr = 32'h1234_5678; asid = 8'h5A; inh = 0; refill = 0;
        pulse();
        chk("R10 badvaddr", badv, 32'h1234_5678);
        chk("R10 context", ctx, 32'h0009_1A20);
        chk("R10 entryhi", ehi, 32'h1234_405A);
        // R10: non-address fault leaves them
        kind = K_SYS; vaddr = 32'hFFFF_FFFF; asid = 8'h11;
        pulse();
        chk("R10 badvaddr kept", badv, 32'h1234_5678);
        chk("R10 entryhi kept", ehi, 32'h1234_405A);

        // R12: idle holds, status mirror follows
        keep_pc = next_pc; keep_epc = epc;
        pc = 32'h0ABC_0000; kind = K_TRAP; ksu = 2'b10; isa = 1'b1; exl = 1'b0;
        repeat (3) @(negedge clk);
        chk("R12 pc held", next_pc, keep_pc);
        chk("R12 epc held", epc, keep_epc);
        chk("R12 mirror ksu/isa/exl", {29'b0, ksu_o, isa_o}, 32'd5);
        chk("R12 mirror exl", {31'b0, exl_o}, 32'd0);

        // R11: entry forces kernel, clears compressed mode, sets exl
        kind = K_SYS; pc = 32'h00A0_0000;
        pulse();
        chk("R11 ksu/isa/exl", {29'b0, ksu_o, isa_o}, 32'd0);
        chk("R11 exl set", {31'b0, exl_o}, 32'd1);
        chk("R1 compressed epc", epc, 32'h00A0_0001);

        // R7: NMI from a delay slot
        keep_epc = epc; ksu = 2'b00; isa = 1'b0; exl = 1'b0; bev = 1'b0;
        kind = K_NMI; pc = 32'h0080_0004; dly = 1; dcmp = 0;
        pulse();
        chk("R7 nmi pc", next_pc, 32'hBFC0_0000);
        chk("R7 nmi errpc", errpc, 32'h0080_0000);
        chk("R7 nmi epc kept", epc, keep_epc);
        chk("R7 nmi erl/bev/bd", {29'b0, erl_o, bev_o, bd}, 32'd6);
        // R7: soft reset with exl set keeps bd
        kind = K_SYS; dly = 1; exl = 0; pc = 32'h00B0_0004;
        pulse();
        kind = K_SRESET; exl = 1; dly = 1; dcmp = 1; pc = 32'h00C0_0010;
        pulse();
        chk("R7 sreset bd kept", {31'b0, bd}, 32'd1);
        chk("R7 sreset errpc", errpc, 32'h00C0_000E);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule